// File: doc/BRIEF.md
# Streaming Record Filter and Product-Sum Aggregator

This block sits beside one flash channel's read path and screens fixed-layout records as their fields go by, one field per beat. Each beat carries a field number, a 32-bit value, an end-of-record mark and a mark that says the record is the last one of the scan. A programmable table holds one predicate per field number. Each predicate is a 3-bit operator and a constant. The field is tested against its own predicate on the beat it arrives, so no record is ever buffered. The tests are ANDed over the record.

Two field numbers, chosen by configuration, supply the multiplicands for the aggregate. When a record ends with its AND flag still set, the product of those two fields is added into a 64-bit sum and a 32-bit match counter is incremented. A start pulse opens a scan. A one-cycle completion pulse marks the end of the scan, and from that pulse the sum and the count can be read. Several instances, one per channel, scan in parallel.

Top module: `rec_filter_agg`

## Requirements
- R1: After reset, `scanDone` and `scanBusy` are 0, and `aggSum` and `matchCount` are 0.
- R2: A `scanStart` pulse clears `aggSum` and `matchCount` and sets `scanBusy`, all visible on the cycle after the pulse.
- R3: The operator codes compare the field value against the constant, both taken as unsigned: 1 = equal, 2 = not equal, 3 = less than, 4 = less or equal, 5 = greater than, 6 = greater or equal. Codes 0 and 7 always pass. Field n uses bits [3n+2:3n] of `predOps` and bits [32n+31:32n] of `predVals`.
- R4: A record qualifies only when every field beat in it passes its predicate. The pass flag starts afresh at 1 for every record, so the result of one record does not carry over to the next.
- R5: A qualifying record adds fieldA × fieldB to `aggSum` (64 bits, wrapping modulo 2^64) and adds 1 to `matchCount`. fieldA is the field whose number equals `aggSelA`, and fieldB is the field whose number equals `aggSelB`. A multiplicand field that is missing from the record counts as 0.
- R6: `scanDone` is high for exactly one cycle. That cycle follows the clock edge that accepted the end-of-record beat carrying `fldLastRec`. `scanBusy` falls on the same cycle.
- R7: While `scanBusy` is 0, field beats are ignored: `aggSum` and `matchCount` hold until the next `scanStart`, and `scanDone` stays 0.
- R8: When `scanStart` and a field beat arrive in the same cycle, the start takes priority and the beat is dropped. A start in the middle of a scan discards all partial results.
- R9: If `aggSelA` equals `aggSelB`, the aggregate is the sum of the squares of that field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| scanStart | input | 1 | Opens a new scan; clears the results |
| fldValid | input | 1 | A field beat is present |
| fldIdx | input | IDX_W | Field number within the record |
| fldData | input | DATA_W | Field value |
| fldEor | input | 1 | This beat is the last field of its record |
| fldLastRec | input | 1 | With fldEor: this record ends the scan |
| predOps | input | NUM_FIELDS*3 | Operator code per field |
| predVals | input | NUM_FIELDS*DATA_W | Comparison constant per field |
| aggSelA | input | IDX_W | Field number of the first multiplicand |
| aggSelB | input | IDX_W | Field number of the second multiplicand |
| scanBusy | output | 1 | A scan is open |
| scanDone | output | 1 | One-cycle completion pulse |
| aggSum | output | ACC_W | Running and final product sum |
| matchCount | output | CNT_W | Number of qualifying records |

## Verification
The results follow a beat by exactly one clock edge. A start pulse or an end-of-record beat is accepted at a rising edge, and from that same edge `aggSum`, `matchCount` and `scanBusy` show the update, while `scanDone` is high until the next edge. The bench drives each beat on a falling edge and holds it for one full cycle. It then samples on the falling edge that follows the accepting rising edge, half a cycle after the update. On that sample it expects the pulse, and one cycle later it expects the pulse to be gone. All expected sums and counts come from a model of the predicates and the products written in the bench, run over operator sweeps and record mixes.

// File: rtl/rec_scan_pkg.sv
package rec_scan_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ANY  = 3'd0,
    OP_EQ   = 3'd1,
    OP_NE   = 3'd2,
    OP_LT   = 3'd3,
    OP_LE   = 3'd4,
    OP_GT   = 3'd5,
    OP_GE   = 3'd6,
    OP_ANY7 = 3'd7
  } predOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clr;     // new scan: zero results
    logic take;    // accept current field beat
    logic recEnd;  // accepted beat closes a record
    logic finish;  // accepted beat closes the scan
  } scanStrb_t;
endpackage

// File: rtl/rec_scan_cmp.sv
module rec_scan_cmp
  import rec_scan_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  predOp_e           opSel,
  input  logic [DATA_W-1:0] fieldVal,
  input  logic [DATA_W-1:0] refVal,
  output logic              hit
);
  always_comb begin
    unique case (opSel)
      OP_EQ:   hit = (fieldVal == refVal);
      OP_NE:   hit = (fieldVal != refVal);
      OP_LT:   hit = (fieldVal <  refVal);
      OP_LE:   hit = (fieldVal <= refVal);
      OP_GT:   hit = (fieldVal >  refVal);
      OP_GE:   hit = (fieldVal >= refVal);
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/rec_scan_ctrl.sv
module rec_scan_ctrl
  import rec_scan_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      scanStart,
  input  logic      fldValid,
  input  logic      fldEor,
  input  logic      fldLastRec,
  output scanStrb_t strb,
  output logic      busy,
  output logic      done
);
  always_comb begin
    strb.clr    = scanStart;
    strb.take   = fldValid && busy && !scanStart;
    strb.recEnd = strb.take && fldEor;
    strb.finish = strb.recEnd && fldLastRec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= strb.finish;
      if (strb.clr)         busy <= 1'b1;
      else if (strb.finish) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/rec_scan_dp.sv
module rec_scan_dp
  import rec_scan_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_FIELDS = 8,
  parameter int ACC_W      = 64,
  parameter int CNT_W      = 32,
  parameter int IDX_W      = $clog2(NUM_FIELDS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  scanStrb_t                  strb,
  input  logic [IDX_W-1:0]           fldIdx,
  input  logic [DATA_W-1:0]          fldData,
  input  logic [NUM_FIELDS*OP_W-1:0] predOps,
  input  logic [NUM_FIELDS*DATA_W-1:0] predVals,
  input  logic [IDX_W-1:0]           aggSelA,
  input  logic [IDX_W-1:0]           aggSelB,
  output logic [ACC_W-1:0]           aggSum,
  output logic [CNT_W-1:0]           matchCount
);
  localparam int PROD_W = 2 * DATA_W;

  logic [NUM_FIELDS-1:0] hitVec;
  logic                  fieldPass;
  logic                  recMatch;
  logic                  curMatch;
  logic [DATA_W-1:0]     opndA, opndB, effA, effB;
  logic [PROD_W-1:0]     prodVal;

  // one comparator per table entry
  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_cmp
    rec_scan_cmp #(.DATA_W(DATA_W)) u_cmp (
      .opSel   (predOp_e'(predOps[gi*OP_W +: OP_W])),
      .fieldVal(fldData),
      .refVal  (predVals[gi*DATA_W +: DATA_W]),
      .hit     (hitVec[gi])
    );
  end

  always_comb begin
    fieldPass = hitVec[fldIdx];
    curMatch  = recMatch && fieldPass;
    effA      = (fldIdx == aggSelA) ? fldData : opndA;
    effB      = (fldIdx == aggSelB) ? fldData : opndB;
    prodVal   = PROD_W'(effA) * PROD_W'(effB);
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clr) begin
      recMatch   <= 1'b1;
      opndA      <= '0;
      opndB      <= '0;
      aggSum     <= '0;
      matchCount <= '0;
    end else if (strb.take) begin
      if (strb.recEnd) begin
        recMatch <= 1'b1;
        opndA    <= '0;
        opndB    <= '0;
        if (curMatch) begin
          aggSum     <= aggSum + ACC_W'(prodVal);
          matchCount <= matchCount + CNT_W'(1);
        end
      end else begin
        recMatch <= curMatch;
        opndA    <= effA;
        opndB    <= effB;
      end
    end
  end
endmodule

// File: rtl/rec_filter_agg.sv
module rec_filter_agg #(
  parameter int DATA_W     = 32,
  parameter int NUM_FIELDS = 8,
  parameter int ACC_W      = 64,
  parameter int CNT_W      = 32,
  parameter int IDX_W      = $clog2(NUM_FIELDS)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         scanStart,
  input  logic                         fldValid,
  input  logic [IDX_W-1:0]             fldIdx,
  input  logic [DATA_W-1:0]            fldData,
  input  logic                         fldEor,
  input  logic                         fldLastRec,
  input  logic [NUM_FIELDS*3-1:0]      predOps,
  input  logic [NUM_FIELDS*DATA_W-1:0] predVals,
  input  logic [IDX_W-1:0]             aggSelA,
  input  logic [IDX_W-1:0]             aggSelB,
  output logic                         scanBusy,
  output logic                         scanDone,
  output logic [ACC_W-1:0]             aggSum,
  output logic [CNT_W-1:0]             matchCount
);
  rec_scan_pkg::scanStrb_t strb;

  rec_scan_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .scanStart (scanStart),
    .fldValid  (fldValid),
    .fldEor    (fldEor),
    .fldLastRec(fldLastRec),
    .strb      (strb),
    .busy      (scanBusy),
    .done      (scanDone)
  );

  rec_scan_dp #(
    .DATA_W(DATA_W), .NUM_FIELDS(NUM_FIELDS), .ACC_W(ACC_W),
    .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .fldIdx    (fldIdx),
    .fldData   (fldData),
    .predOps   (predOps),
    .predVals  (predVals),
    .aggSelA   (aggSelA),
    .aggSelB   (aggSelB),
    .aggSum    (aggSum),
    .matchCount(matchCount)
  );
endmodule

// File: rtl/rec_filter_agg_chk.sv
module rec_filter_agg_chk #(
  parameter int DATA_W     = 32,
  parameter int NUM_FIELDS = 8,
  parameter int ACC_W      = 64,
  parameter int CNT_W      = 32,
  parameter int IDX_W      = $clog2(NUM_FIELDS)
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         scanStart,
  input logic                         fldValid,
  input logic [IDX_W-1:0]             fldIdx,
  input logic [DATA_W-1:0]            fldData,
  input logic                         fldEor,
  input logic                         fldLastRec,
  input logic [NUM_FIELDS*3-1:0]      predOps,
  input logic [NUM_FIELDS*DATA_W-1:0] predVals,
  input logic [IDX_W-1:0]             aggSelA,
  input logic [IDX_W-1:0]             aggSelB,
  input logic                         scanBusy,
  input logic                         scanDone,
  input logic [ACC_W-1:0]             aggSum,
  input logic [CNT_W-1:0]             matchCount
);
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    scanStart |=> (aggSum == '0) && (matchCount == '0) && scanBusy);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |=> !scanDone);

  a_r6_done_cause: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |-> $past(fldValid && fldEor && fldLastRec && scanBusy && !scanStart));

  a_r6_busy_falls: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |-> !scanBusy);

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!scanBusy && !scanStart) |=> $stable(aggSum) && $stable(matchCount) && !scanDone);

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rstN)
    !scanStart |=> (matchCount == $past(matchCount)) ||
                   (matchCount == $past(matchCount) + CNT_W'(1)));
endmodule

bind rec_filter_agg rec_filter_agg_chk #(
  .DATA_W(DATA_W), .NUM_FIELDS(NUM_FIELDS), .ACC_W(ACC_W),
  .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/rec_filter_agg_bench.sv
module rec_filter_agg_bench;
  localparam int DW = 32;
  localparam int NF = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scanStart = 1'b0;
  logic fldValid = 1'b0;
  logic [IW-1:0] fldIdx = '0;
  logic [DW-1:0] fldData = '0;
  logic fldEor = 1'b0;
  logic fldLastRec = 1'b0;
  logic [NF*3-1:0] predOps = '0;
  logic [NF*DW-1:0] predVals = '0;
  logic [IW-1:0] aggSelA = '0;
  logic [IW-1:0] aggSelB = '0;
  logic scanBusy, scanDone;
  logic [63:0] aggSum;
  logic [31:0] matchCount;

  int nRun = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  rec_filter_agg u_rec_filter_agg (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit evalOp(input int op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      1: return a == b;
      2: return a != b;
      3: return a < b;
      4: return a <= b;
      5: return a > b;
      6: return a >= b;
      default: return 1'b1;
    endcase
  endfunction

  task automatic startScan();
    @(negedge clk); scanStart = 1'b1;
    @(negedge clk); scanStart = 1'b0;
  endtask

  // one beat held for a full cycle; returns at the falling edge after acceptance
  task automatic beat(input int idx, input logic [31:0] d, input bit eor, input bit last);
    @(negedge clk);
    fldValid = 1'b1; fldIdx = IW'(idx); fldData = d; fldEor = eor; fldLastRec = last;
    @(negedge clk);
    fldValid = 1'b0; fldEor = 1'b0; fldLastRec = 1'b0;
  endtask

  task automatic checkDone(input string tag);
    check({tag, " done pulse"}, 64'(scanDone), 64'd1);
    check({tag, " busy low"}, 64'(scanBusy), 64'd0);
    @(negedge clk);
    check({tag, " done one cycle"}, 64'(scanDone), 64'd0);
  endtask

  initial begin
    logic [63:0] expSum;
    int expCnt;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 done", 64'(scanDone), 0);
    check("R1 busy", 64'(scanBusy), 0);
    check("R1 sum", aggSum, 0);
    check("R1 count", 64'(matchCount), 0);
    rstN = 1'b1;

    // R3/R9: sweep every operator on field 0 against constant 2, sum of squares
    aggSelA = 0; aggSelB = 0;
    predVals[0 +: DW] = 32'd2;
    for (int op = 0; op < 8; op++) begin
      predOps = '0;
      predOps[0 +: 3] = 3'(op);
      startScan();
      check("R2 cleared sum", aggSum, 0);
      check("R2 busy set", 64'(scanBusy), 1);
      expSum = 0; expCnt = 0;
      for (int d = 0; d < 5; d++) begin
        if (evalOp(op, 32'(d), 32'd2)) begin expSum += 64'(d * d); expCnt++; end
        beat(0, 32'(d), 1'b1, d == 4);
      end
      checkDone("R6 sweep");
      check($sformatf("R3 R9 op%0d sum", op), aggSum, expSum);
      check($sformatf("R3 op%0d count", op), 64'(matchCount), 64'(expCnt));
    end

    // R4/R5: four-field records, range predicates, product of fields 1 and 2
    predOps = '0; predVals = '0;
    predOps[0 +: 3] = 3'd6; predVals[0*DW +: DW] = 32'd10;
    predOps[3 +: 3] = 3'd3; predVals[1*DW +: DW] = 32'd20;
    predOps[6 +: 3] = 3'd5; predVals[2*DW +: DW] = 32'd5;
    aggSelA = 1; aggSelB = 2;
    startScan();
    expSum = 0; expCnt = 0;
    for (int r = 0; r < 12; r++) begin
      logic [31:0] f0, f1, f2;
      f0 = 32'(9 + r % 3);
      f1 = 32'(19 + (r / 3) % 2);
      f2 = 32'(5 + r / 6);
      if (f0 >= 10 && f1 < 20 && f2 > 5) begin expSum += 64'(f1) * 64'(f2); expCnt++; end
      beat(0, f0, 1'b0, 1'b0);
      beat(1, f1, 1'b0, 1'b0);
      beat(2, f2, 1'b0, 1'b0);
      beat(3, 32'(r), 1'b1, r == 11);
    end
    checkDone("R6 multi");
    check("R4 R5 multi sum", aggSum, expSum);
    check("R4 multi count", 64'(matchCount), 64'(expCnt));

    // R5: full-width products wrap mod 2^64; missing multiplicand counts 0
    predOps = '0;
    aggSelA = 0; aggSelB = 1;
    startScan();
    for (int r = 0; r < 3; r++) begin
      beat(0, 32'hFFFF_FFFF, 1'b0, 1'b0);
      beat(1, 32'hFFFF_FFFF, 1'b1, 1'b0);
    end
    beat(0, 32'd5, 1'b1, 1'b1);
    expSum = 64'hFFFF_FFFE_0000_0001 * 64'd3;
    checkDone("R6 wide");
    check("R5 wide sum", aggSum, expSum);
    check("R5 wide count", 64'(matchCount), 64'd4);

    // R8: start mid-scan, colliding with a beat
    startScan();
    beat(0, 32'd3, 1'b0, 1'b0); beat(1, 32'd4, 1'b1, 1'b0);
    beat(0, 32'd5, 1'b0, 1'b0); beat(1, 32'd6, 1'b1, 1'b0);
    check("R8 partial sum", aggSum, 64'd42);
    @(negedge clk);
    scanStart = 1'b1; fldValid = 1'b1; fldIdx = 0; fldData = 32'd100; fldEor = 1'b1;
    @(negedge clk);
    scanStart = 1'b0; fldValid = 1'b0; fldEor = 1'b0;
    check("R8 restart sum", aggSum, 0);
    check("R8 restart count", 64'(matchCount), 0);
    beat(0, 32'd7, 1'b0, 1'b0); beat(1, 32'd8, 1'b1, 1'b1);
    checkDone("R8");
    check("R8 final sum", aggSum, 64'd56);
    check("R8 final count", 64'(matchCount), 64'd1);

    // R7: beats while idle are ignored
    beat(0, 32'd9, 1'b0, 1'b0);
    beat(1, 32'd9, 1'b1, 1'b1);
    check("R7 idle done", 64'(scanDone), 0);
    repeat (3) @(negedge clk);
    check("R7 idle sum", aggSum, 64'd56);
    check("R7 idle count", 64'(matchCount), 64'd1);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule